// File: doc/BRIEF.md
# Fifteen-Cent Coin Credit Controller

This block is the control core of a single-item dispenser whose item costs 15 cents. On each rising clock edge it samples two one-cycle coin strobes, one for a nickel (5 cents) and one for a dime (10 cents). It keeps the credit collected so far in a two-bit register. It raises its open output once the credit reaches 15 cents or more.

Credit stops rising at a single 15-or-more level. No change is computed and no refund is made. Once the open output is set, it stays set until a synchronous reset returns the credit to zero. The open output depends only on the stored credit. It therefore changes one clock edge after the coin that completes the price, and never in the same cycle as that coin.

If both strobes arrive in the same cycle, the controller treats the cycle as having no coin. This gives a defined result for an input pair the coin path should never produce.

Top module: `coin_vend_ctrl`

## Requirements
- R1: A synchronous reset, sampled high at a rising edge, sets the credit to 0 cents, and `open_o` reads 0 after that edge.
- R2: At 0 cents, a lone nickel raises the credit to 5 cents and a lone dime raises it to 10 cents.
- R3: At 5 cents, a lone nickel raises the credit to 10 cents and a lone dime raises it to 15-or-more.
- R4: At 10 cents, a lone nickel or a lone dime raises the credit to 15-or-more.
- R5: In a cycle with neither strobe high, the credit is unchanged.
- R6: Once the credit is 15-or-more, it stays there for any coin input until reset.
- R7: `open_o` is 1 exactly when the credit is 15-or-more (encoding 2'b11; the other levels are 0 = 2'b00, 5 = 2'b01, 10 = 2'b10). It does not change in the cycle a coin is applied, only after the next rising edge.
- R8: In a cycle with both strobes high, both are ignored and the credit is unchanged.
- R9: Reset takes priority over any coin strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| nickel_i | input | 1 | One-cycle strobe: a 5-cent coin was inserted |
| dime_i | input | 1 | One-cycle strobe: a 10-cent coin was inserted |
| open_o | output | 1 | Dispense enable; high while the credit is 15 cents or more |

## Verification
Each coin or reset applied before a rising edge shows its effect on `open_o` right after that edge and no earlier. The result is due one edge after the stimulus. The bench drives inputs on the falling edge, waits for the next rising edge, and samples 1 ns later, before any new input is driven.

The credit levels below 15 cents are not visible at the port. The bench infers them from how many further coins it takes to raise `open_o`. One directed check confirms that `open_o` has not yet moved while a completing coin is still held, before the edge that samples it.

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic nickel_i,
  input  logic dime_i,
  output logic open_o
);

  typedef enum logic [1:0] {
    CR_0   = 2'b00,
    CR_5   = 2'b01,
    CR_10  = 2'b10,
    CR_15P = 2'b11
  } credit_t;

  credit_t credit_q, credit_d;
  logic    one_coin;

  assign one_coin = nickel_i ^ dime_i;

  always_comb begin
    credit_d = credit_q;
    if (one_coin) begin
      unique case (credit_q)
        CR_0:    credit_d = dime_i ? CR_10 : CR_5;
        CR_5:    credit_d = dime_i ? CR_15P : CR_10;
        CR_10:   credit_d = CR_15P;
        default: credit_d = CR_15P;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) credit_q <= CR_0;
    else     credit_q <= credit_d;
  end

  assign open_o = (credit_q == CR_15P);

endmodule

// File: rtl/coin_vend_ctrl_chk.sv
module coin_vend_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       nickel_i,
  input logic       dime_i,
  input logic       open_o,
  input logic [1:0] credit_q
);

  assert_reset_closes_R1: assert property (@(posedge clk)
    rst |=> !open_o);

  assert_zero_nickel_R2: assert property (@(posedge clk) disable iff (rst)
    (credit_q == 2'b00 && nickel_i && !dime_i) |=> (credit_q == 2'b01));

  assert_five_dime_R3: assert property (@(posedge clk) disable iff (rst)
    (credit_q == 2'b01 && dime_i && !nickel_i) |=> open_o);

  assert_ten_any_R4: assert property (@(posedge clk) disable iff (rst)
    (credit_q == 2'b10 && (nickel_i != dime_i)) |=> open_o);

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!nickel_i && !dime_i) |=> $stable(credit_q));

  assert_open_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    open_o |=> open_o);

  assert_both_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (nickel_i && dime_i) |=> $stable(credit_q));

endmodule

bind coin_vend_ctrl coin_vend_ctrl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .nickel_i (nickel_i),
  .dime_i   (dime_i),
  .open_o   (open_o),
  .credit_q (credit_q)
);

// File: tb/sim_coin_vend_ctrl.sv
`timescale 1ns/1ps
module sim_coin_vend_ctrl;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nickel_i = 1'b0;
  logic dime_i = 1'b0;
  logic open_o;
  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  coin_vend_ctrl u0 (
    .clk      (clk),
    .rst      (rst),
    .nickel_i (nickel_i),
    .dime_i   (dime_i),
    .open_o   (open_o)
  );

  // row: {req[3:0], rst, nickel, dime, expected open after the edge}
  localparam int NROWS = 29;
  localparam logic [7:0] VEC [NROWS] = '{
    {4'd1, 4'b1000},  // R1 reset
    {4'd2, 4'b0100},  // R2 0 -> 5
    {4'd3, 4'b0100},  // R3 5 -> 10
    {4'd5, 4'b0000},  // R5 hold at 10
    {4'd4, 4'b0101},  // R4 10 + nickel -> 15+
    {4'd6, 4'b0001},  // R6 hold
    {4'd6, 4'b0101},  // R6
    {4'd6, 4'b0011},  // R6
    {4'd6, 4'b0111},  // R6
    {4'd1, 4'b1000},  // R1 reset clears open
    {4'd2, 4'b0010},  // R2 0 -> 10
    {4'd4, 4'b0011},  // R4 10 + dime -> 15+
    {4'd1, 4'b1000},  // R1
    {4'd2, 4'b0100},  // R2 0 -> 5
    {4'd3, 4'b0011},  // R3 5 + dime -> 15+
    {4'd9, 4'b1110},  // R9 reset beats coins
    {4'd8, 4'b0110},  // R8 both at 0 ignored
    {4'd2, 4'b0100},  // R2 0 -> 5 (proves 0 held)
    {4'd8, 4'b0110},  // R8 both at 5 ignored
    {4'd5, 4'b0000},  // R5 hold
    {4'd3, 4'b0100},  // R3 5 -> 10 (proves 5 held)
    {4'd8, 4'b0110},  // R8 both at 10 ignored
    {4'd5, 4'b0000},  // R5
    {4'd4, 4'b0011},  // R4 10 -> 15+
    {4'd9, 4'b1010},  // R9 reset beats dime
    {4'd1, 4'b0000},  // R1 stays closed
    {4'd2, 4'b0100},  // R2
    {4'd3, 4'b0100},  // R3
    {4'd4, 4'b0011}   // R4
  };

  task automatic check(input int req, input logic exp);
    checks++;
    if (open_o !== exp) begin
      errors++;
      $display("FAIL R%0d: open_o=%b expected %b", req, open_o, exp);
    end
  endtask

  task automatic step(input logic r, input logic n, input logic d);
    @(negedge clk);
    rst = r; nickel_i = n; dime_i = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    for (int i = 0; i < NROWS; i++) begin
      step(VEC[i][3], VEC[i][2], VEC[i][1]);
      check(int'(VEC[i][7:4]), VEC[i][0]);
    end

    // R5: long idle at 10 cents keeps open low, then one nickel opens
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 20; k++) begin
      step(1'b0, 1'b0, 1'b0);
      check(5, 1'b0);
    end

    // R7: completing coin held before the edge leaves open unchanged
    @(negedge clk);
    rst = 1'b0; nickel_i = 1'b1; dime_i = 1'b0;
    #1 check(7, 1'b0);
    @(posedge clk);
    #1 check(7, 1'b1);

    // R6: many cycles of varied coins keep open high
    for (int k = 0; k < 12; k++) begin
      step(1'b0, k[0], k[1]);
      check(6, 1'b1);
    end

    // R1: reset held several cycles with coins present
    for (int k = 0; k < 3; k++) begin
      step(1'b1, 1'b1, 1'b0);
      check(1, 1'b0);
    end
    step(1'b0, 1'b0, 1'b0);
    check(1, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule